// File: doc/BRIEF.md
# Three-Tier Interrupt Gating Controller

This block sits between a set of peripheral modules and the processor core and decides whether the core is asked to take an interrupt. Each peripheral module owns a group of interrupt sources. Every source has a sticky flag, set by a one-cycle event pulse from its peripheral, and a local enable bit. A shared mask register holds one bit per module, and a single global enable bit sits in front of everything. A source can only interrupt the core when its local enable, its module's mask bit and the global enable are all set.

Software reaches the block through a small register port. Writes take effect at the next clock edge, and reads are combinational. Software clears a flag by writing a 1 to its bit position, and an event that arrives in the same cycle as the clear keeps the flag set. Two read-only identification views help the handler locate the cause. The module view has one bit per module that reports an enabled, flagged source in that module, whatever the mask and global enable hold. The per-module source view lists which of that module's sources are both flagged and enabled. Because every module mask bit sits in one register, software can change the relative priority of several modules with a single write.

The request output is the OR over all modules of the identification bit ANDed with the mask bit, ANDed with the global enable, and it is registered, so it follows the register state with one cycle of latency.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_req` is 0.
- R2: A one-cycle pulse on `src_evt[m*N_SRC+s]` sets flag bit s of module m at the next clock edge. The flag then stays set, with no further events and no clearing write, for as many cycles as it is observed.
- R3: A write to the flag register of module m (address 4+4m) clears exactly those flag bits where the write data holds 1. Bits written with 0 keep their value.
- R4: When an event and a clearing write reach the same flag bit in the same cycle, the flag is set after that edge.
- R5: `irq_req` is 1 exactly one cycle after the state in which some source has flag, local enable, module mask bit and global enable all set. With any one of the three enable tiers removed it returns to 0 one cycle later.
- R6: The global enable is bit 0 of the control register at address 0. It resets to 0 and reads back what was written.
- R7: The module mask register at address 1 holds bit m for module m. A single write there can enable several modules at once.
- R8: The module identification register at address 2 reads bit m = 1 when module m has any source with both flag and local enable set, independent of the mask and global enable.
- R9: The source identification register of module m at address 6+4m reads bit s = flag[s] AND enable[s] of that module.
- R10: Writes to the identification registers (address 2 and 6+4m) change no register state.
- R11: The local enable register of module m at address 5+4m is read/write, with bit s enabling source s.
- R12: Addresses that map to no register read 0, and writes to them change no register state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | N_MOD*N_SRC | One-cycle event pulses, source s of module m at bit m*N_SRC+s |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address (AW = clog2(4+4*N_MOD)) |
| reg_wdata | input | DW | Write data (DW = max(N_SRC, N_MOD)) |
| reg_rdata | output | DW | Combinational read data for reg_addr |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
The bench builds the block with N_MOD = 4 and N_SRC = 8. This keeps the address map down to twenty words, so every module register and several unmapped holes (3, 7, 31) can be reached directly. With four modules, one mask write can enable a non-adjacent pair (modules 0 and 3) while a third module stays pending, which shows that the module identification view ignores masking. The narrower source count puts the top source bit at 7 and the data bus at 8 bits, so edge bits of both the flag and enable registers are exercised.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
    // Fixed system words
    localparam int ADDR_GCTL  = 0;
    localparam int ADDR_MASK  = 1;
    localparam int ADDR_MID   = 2;
    // Per-module window: MOD_BASE + MOD_STRIDE*m + offset
    localparam int MOD_BASE   = 4;
    localparam int MOD_STRIDE = 4;
    localparam int OFS_FLAG   = 0;
    localparam int OFS_EN     = 1;
    localparam int OFS_SID    = 2;

    function automatic int map_words(input int n_mod);
        return MOD_BASE + MOD_STRIDE * n_mod;
    endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_hier_pkg::*;
#(
    parameter int N_SRC   = 16,
    parameter int MOD_IDX = 0,
    parameter int AW      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] flag_q_o,
    output logic [N_SRC-1:0] en_q_o,
    output logic [N_SRC-1:0] sub_id,
    output logic             pend
);
    localparam logic [AW-1:0] A_FLAG = AW'(MOD_BASE + MOD_STRIDE*MOD_IDX + OFS_FLAG);
    localparam logic [AW-1:0] A_EN   = AW'(MOD_BASE + MOD_STRIDE*MOD_IDX + OFS_EN);

    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] en;
    } bank_t;

    bank_t st_d, st_q;
    logic  clr_hit, en_hit;

    always_comb begin
        st_d    = st_q;
        clr_hit = wr && (addr == A_FLAG);
        en_hit  = wr && (addr == A_EN);
        // clear first, then OR events so a same-cycle event wins
        if (clr_hit)
            st_d.flag = st_q.flag & ~wdata;
        st_d.flag = st_d.flag | evt;
        if (en_hit)
            st_d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flag_q_o = st_q.flag;
    assign en_q_o   = st_q.en;
    assign sub_id   = st_q.flag & st_q.en;
    assign pend     = |sub_id;

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st_q.flag & $past(evt)) == $past(evt))); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == A_FLAG)) |=> ((st_q.flag & $past(st_q.flag)) == $past(st_q.flag))); // R3
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == A_EN)) |=> $stable(st_q.en)); // R11
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_hier_pkg::*;
#(
    parameter int N_MOD = 8,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MOD-1:0] pend,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [N_MOD-1:0] wdata,
    output logic             gie_q_o,
    output logic [N_MOD-1:0] mask_q_o,
    output logic             irq_req
);
    localparam logic [AW-1:0] A_GCTL = AW'(ADDR_GCTL);
    localparam logic [AW-1:0] A_MASK = AW'(ADDR_MASK);

    typedef struct packed {
        logic             gie;
        logic [N_MOD-1:0] mask;
        logic             irq;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && (addr == A_GCTL))
            st_d.gie = wdata[0];
        if (wr && (addr == A_MASK))
            st_d.mask = wdata;
        st_d.irq = st_q.gie && (|(pend & st_q.mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign gie_q_o  = st_q.gie;
    assign mask_q_o = st_q.mask;
    assign irq_req  = st_q.irq;

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(st_q.gie)); // R5
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (|($past(pend) & $past(st_q.mask)))); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == A_MASK)) |=> $stable(st_q.mask)); // R7
    AST_GIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == A_GCTL)) |=> $stable(st_q.gie)); // R6
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_hier_pkg::*;
#(
    parameter int N_MOD = 8,
    parameter int N_SRC = 16,
    parameter int AW    = 6,
    parameter int DW    = 16
) (
    input  logic                   gie,
    input  logic [N_MOD-1:0]       mask,
    input  logic [N_MOD-1:0]       mod_id,
    input  logic [N_MOD*N_SRC-1:0] flags,
    input  logic [N_MOD*N_SRC-1:0] ens,
    input  logic [N_MOD*N_SRC-1:0] sids,
    input  logic [AW-1:0]          addr,
    output logic [DW-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_GCTL))
            rdata[0] = gie;
        if (addr == AW'(ADDR_MASK))
            rdata[N_MOD-1:0] = mask;
        if (addr == AW'(ADDR_MID))
            rdata[N_MOD-1:0] = mod_id;
        for (int m = 0; m < N_MOD; m++) begin
            if (addr == AW'(MOD_BASE + MOD_STRIDE*m + OFS_FLAG))
                rdata[N_SRC-1:0] = flags[m*N_SRC +: N_SRC];
            if (addr == AW'(MOD_BASE + MOD_STRIDE*m + OFS_EN))
                rdata[N_SRC-1:0] = ens[m*N_SRC +: N_SRC];
            if (addr == AW'(MOD_BASE + MOD_STRIDE*m + OFS_SID))
                rdata[N_SRC-1:0] = sids[m*N_SRC +: N_SRC];
        end
    end
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
    import irq_hier_pkg::*;
#(
    parameter  int N_MOD = 8,
    parameter  int N_SRC = 16,
    localparam int AW    = $clog2(map_words(N_MOD)),
    localparam int DW    = (N_SRC > N_MOD) ? N_SRC : N_MOD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_MOD*N_SRC-1:0] src_evt,
    input  logic                   reg_wr,
    input  logic [AW-1:0]          reg_addr,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    output logic                   irq_req
);
    logic [N_MOD*N_SRC-1:0] flags, ens, sids;
    logic [N_MOD-1:0]       mod_id;
    logic [N_MOD-1:0]       mask;
    logic                   gie;

    for (genvar m = 0; m < N_MOD; m++) begin : g_bank
        irq_src_bank #(
            .N_SRC   (N_SRC),
            .MOD_IDX (m),
            .AW      (AW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (src_evt[m*N_SRC +: N_SRC]),
            .wr       (reg_wr),
            .addr     (reg_addr),
            .wdata    (reg_wdata[N_SRC-1:0]),
            .flag_q_o (flags[m*N_SRC +: N_SRC]),
            .en_q_o   (ens[m*N_SRC +: N_SRC]),
            .sub_id   (sids[m*N_SRC +: N_SRC]),
            .pend     (mod_id[m])
        );
    end

    irq_gate #(
        .N_MOD (N_MOD),
        .AW    (AW)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (mod_id),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata[N_MOD-1:0]),
        .gie_q_o  (gie),
        .mask_q_o (mask),
        .irq_req  (irq_req)
    );

    irq_rd_mux #(
        .N_MOD (N_MOD),
        .N_SRC (N_SRC),
        .AW    (AW),
        .DW    (DW)
    ) u_rd (
        .gie    (gie),
        .mask   (mask),
        .mod_id (mod_id),
        .flags  (flags),
        .ens    (ens),
        .sids   (sids),
        .addr   (reg_addr),
        .rdata  (reg_rdata)
    );

    AST_IRQ_OFF_NO_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq_req); // R5
endmodule

// File: tb/irq_hier_ctrl_test.sv
module irq_hier_ctrl_test;
    localparam int NM = 4;
    localparam int NS = 8;
    localparam int AW = 5;
    localparam int DW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NM*NS-1:0] src_evt = '0;
    logic             reg_wr = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [DW-1:0]    reg_wdata = '0;
    logic [DW-1:0]    reg_rdata;
    logic             irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    irq_hier_ctrl #(.N_MOD(NM), .N_SRC(NS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic [AW-1:0] a_flag(input int m); return AW'(4 + 4*m); endfunction
    function automatic logic [AW-1:0] a_en(input int m);   return AW'(5 + 4*m); endfunction
    function automatic logic [AW-1:0] a_sid(input int m);  return AW'(6 + 4*m); endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int m, input int s);
        @(negedge clk);
        src_evt[m*NS + s] = 1'b1;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int a = 0; a < 20; a++) begin
            rd_reg(AW'(a), v);
            check("R1 reset value", v, 0);
        end
        rd_reg(AW'(0), v);
        check("R6 global enable resets 0", v, 0);
        check("R1 irq_req after reset", irq_req, 0);
    endtask

    task automatic t_sticky();
        logic [DW-1:0] v;
        pulse(1, 3);
        rd_reg(a_flag(1), v);
        check("R2 flag set by event", v, 8'h08);
        repeat (5) @(negedge clk);
        rd_reg(a_flag(1), v);
        check("R2 flag still set", v, 8'h08);
        check("R5 no irq without enables", irq_req, 0);
    endtask

    task automatic t_w1c();
        logic [DW-1:0] v;
        pulse(1, 0);
        wr_reg(a_flag(1), 8'h00);
        rd_reg(a_flag(1), v);
        check("R3 zero write keeps flags", v, 8'h09);
        wr_reg(a_flag(1), 8'h08);
        rd_reg(a_flag(1), v);
        check("R3 one clears only that bit", v, 8'h01);
        wr_reg(a_flag(1), 8'hFF);
        rd_reg(a_flag(1), v);
        check("R3 full clear", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        @(negedge clk);
        src_evt[0*NS + 7] = 1'b1;
        reg_wr = 1'b1; reg_addr = a_flag(0); reg_wdata = 8'h80;
        @(negedge clk);
        src_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd_reg(a_flag(0), v);
        check("R4 event wins over clear", v, 8'h80);
        wr_reg(a_flag(0), 8'h80);
        rd_reg(a_flag(0), v);
        check("R4 later clear works", v, 8'h00);
    endtask

    task automatic t_tiers();
        logic [DW-1:0] v;
        wr_reg(a_en(2), 8'h05);
        rd_reg(a_en(2), v);
        check("R11 enable readback", v, 8'h05);
        pulse(2, 0);
        pulse(2, 1);
        rd_reg(a_sid(2), v);
        check("R9 source id flag&enable", v, 8'h01);
        rd_reg(AW'(2), v);
        check("R8 module id unmasked", v, 8'h04);
        wr_reg(AW'(1), 8'h04);
        @(negedge clk);
        check("R5 no irq with gie 0", irq_req, 0);
        wr_reg(AW'(0), 8'h01);
        rd_reg(AW'(0), v);
        check("R6 gie readback", v, 8'h01);
        check("R5 irq latency cycle 0", irq_req, 0);
        @(negedge clk);
        check("R5 irq asserted", irq_req, 1);
        wr_reg(AW'(1), 8'h00);
        check("R5 mask removal latency", irq_req, 1);
        @(negedge clk);
        check("R5 irq drops on mask", irq_req, 0);
        wr_reg(AW'(1), 8'h04);
        @(negedge clk);
        check("R5 irq back", irq_req, 1);
        wr_reg(a_en(2), 8'h00);
        @(negedge clk);
        check("R5 irq drops on local enable", irq_req, 0);
        rd_reg(AW'(2), v);
        check("R8 module id follows enable", v, 8'h00);
        wr_reg(a_en(2), 8'h05);
        wr_reg(AW'(0), 8'h00);
        @(negedge clk);
        check("R5 irq drops on gie", irq_req, 0);
    endtask

    task automatic t_multi_mask();
        logic [DW-1:0] v;
        wr_reg(a_en(0), 8'h01);
        wr_reg(a_en(3), 8'h80);
        pulse(0, 0);
        pulse(3, 7);
        rd_reg(AW'(2), v);
        check("R8 module id three modules", v, 8'h0D);
        rd_reg(a_sid(3), v);
        check("R9 source id top bit", v, 8'h80);
        wr_reg(AW'(0), 8'h01);
        wr_reg(AW'(1), 8'h09);
        rd_reg(AW'(1), v);
        check("R7 one write sets two mask bits", v, 8'h09);
        @(negedge clk);
        check("R7 irq from multi-module mask", irq_req, 1);
        wr_reg(a_flag(0), 8'h01);
        wr_reg(a_flag(3), 8'h80);
        @(negedge clk);
        check("R7 irq gone after clearing masked modules", irq_req, 0);
        wr_reg(AW'(1), 8'h00);
    endtask

    task automatic t_readonly();
        logic [DW-1:0] v;
        wr_reg(AW'(2), 8'hFF);
        wr_reg(a_sid(2), 8'hFF);
        rd_reg(AW'(2), v);
        check("R10 module id unchanged", v, 8'h04);
        rd_reg(a_sid(2), v);
        check("R10 source id unchanged", v, 8'h01);
        rd_reg(a_flag(2), v);
        check("R10 flags unchanged", v, 8'h03);
        rd_reg(a_en(2), v);
        check("R10 enables unchanged", v, 8'h05);
        rd_reg(AW'(1), v);
        check("R10 mask unchanged", v, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] v;
        rd_reg(AW'(3), v);
        check("R12 hole 3 reads 0", v, 0);
        rd_reg(AW'(7), v);
        check("R12 hole 7 reads 0", v, 0);
        rd_reg(AW'(31), v);
        check("R12 hole 31 reads 0", v, 0);
        wr_reg(AW'(3), 8'hFF);
        wr_reg(AW'(31), 8'hFF);
        rd_reg(AW'(0), v);
        check("R12 gie unchanged", v, 8'h01);
        rd_reg(AW'(1), v);
        check("R12 mask unchanged", v, 8'h00);
        rd_reg(a_flag(2), v);
        check("R12 flags unchanged", v, 8'h03);
        check("R12 irq stays low", irq_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_w1c();
        t_collide();
        t_tiers();
        t_multi_mask();
        t_readonly();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule